// File: doc/BRIEF.md
# Delay Time Selector Encoder

This block turns eight momentary touch inputs into one held delay-time choice. Each input is synchronised and debounced. A clean press latches its option and clears every other one, so exactly one option is active at any time. The options double in length from the shortest to the longest. The active option leaves the block as a 7-bit thermometer word, which the delay memory uses to mask address bits. Option k drives the k lowest bits high.

Whenever the held option changes, the block produces a mute pulse whose length in clock cycles is a parameter. That pulse silences the delayed-signal output converters while the memory addressing settles. The mode input sets how the mute reaches the three converters. In reverb mode all three follow the pulse. In echo mode converters one and two (counting from zero) stay muted, and converter zero still follows the pulse.

Top module: `dly_sel_top`

## Requirements
- R1: After reset, option 0 is selected, `sel_code_o` is 0 and `mute_o[0]` is 0 (no mute pending).
- R2: While option k (0..7) is held, `sel_code_o` equals 2^k-1. Bit j (bit 0 = LSB) is 1 exactly when k > j, so option 7 gives 127.
- R3: A debounced press of input k makes option k the only selection. Releasing the input keeps that option held.
- R4: When several debounced presses arrive in the same cycle, the lowest-index input is selected.
- R5: An input level must stay unchanged for DEB_CYCLES consecutive synchronised samples before it counts. A shorter pulse changes neither the selection nor the mute outputs.
- R6: Each change of the held option drives `mute_o[0]` high (1 = muted) for exactly MUTE_CYCLES consecutive cycles.
- R7: A press of the option that is already held produces no mute pulse.
- R8: A further change during a mute pulse restarts the count. The muted span then equals the gap between the two changes plus MUTE_CYCLES.
- R9: With `reverb_i` = 1, `mute_o[1]` and `mute_o[2]` equal `mute_o[0]` in every cycle.
- R10: With `reverb_i` = 0, `mute_o[2:1]` is 2'b11 from the cycle after the mode is sampled, while `mute_o[0]` still follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| touch_i | input | 8 | Raw touch inputs, one per option, active high |
| reverb_i | input | 1 | 1 = reverb mode, 0 = echo mode |
| sel_code_o | output | 7 | Thermometer code of the held option |
| mute_o | output | 3 | Per-converter mute, 1 = muted |

## Verification
The bench builds the block with DEB_CYCLES = 4 and MUTE_CYCLES = 20. With these values, pulses shorter than the debounce window and restarted mute spans both fit in windows of a few dozen cycles. The cycle counts make pulse-length and restart arithmetic exact: a press ten cycles after another must give a 30-cycle muted span. A 2-cycle glitch sits clearly below the 4-sample acceptance threshold.

// File: rtl/dly_sel_pkg.sv
package dly_sel_pkg;
  localparam int unsigned OPT_N  = 8;
  localparam int unsigned CODE_W = OPT_N - 1;
  localparam int unsigned CONV_N = 3;

  typedef logic [OPT_N-1:0]  opt_vec_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CONV_N-1:0] conv_vec_t;

  typedef enum logic {MODE_ECHO = 1'b0, MODE_REVERB = 1'b1} mode_e;
endpackage

// File: rtl/dly_sel_debounce.sv
module dly_sel_debounce #(
  parameter int unsigned DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic press_o
);
  localparam int unsigned CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic             sync_a, sync_b;
  logic             stable_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= raw_i;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stable_q <= 1'b0;
      run_q    <= '0;
      press_o  <= 1'b0;
    end else begin
      press_o <= 1'b0;
      if (sync_b != stable_q) begin
        if (run_q == CNT_LAST) begin
          stable_q <= sync_b;
          run_q    <= '0;
          press_o  <= sync_b;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_o = stable_q;

  // a press event only comes from a low-to-high flip of the filtered level
  AST_PRESS_RISE: assert property (@(posedge clk) disable iff (rst)
    press_o |-> (stable_q && !$past(stable_q))); // R5
endmodule

// File: rtl/dly_sel_latch.sv
module dly_sel_latch
  import dly_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  opt_vec_t press_i,
  output opt_vec_t sel_o,
  output logic     change_o
);
  opt_vec_t pick;

  always_comb begin
    pick = '0;
    for (int i = OPT_N - 1; i >= 0; i--) begin
      if (press_i[i]) pick = opt_vec_t'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o    <= opt_vec_t'(1);
      change_o <= 1'b0;
    end else begin
      change_o <= 1'b0;
      if (|press_i) begin
        sel_o    <= pick;
        change_o <= (pick != sel_o);
      end
    end
  end

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_o) == 1); // R3

  AST_LOW_WINS: assert property (@(posedge clk) disable iff (rst)
    (press_i[0]) |=> sel_o[0]); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (press_i == '0) |=> $stable(sel_o)); // R3
endmodule

// File: rtl/dly_sel_mute.sv
module dly_sel_mute #(
  parameter int unsigned MUTE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(MUTE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MUTE_CYCLES);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (trig_i) begin
      left_q <= CNT_LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active_o = (left_q != '0);

  AST_MUTE_LOAD: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> (left_q == CNT_LOAD)); // R8

  AST_MUTE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (!trig_i && left_q != '0) |=> (left_q == $past(left_q) - 1'b1)); // R6
endmodule

// File: rtl/dly_sel_top.sv
module dly_sel_top
  import dly_sel_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 4,
  parameter int unsigned MUTE_CYCLES = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPT_N-1:0]    touch_i,
  input  logic                reverb_i,
  output logic [CODE_W-1:0]   sel_code_o,
  output logic [CONV_N-1:0]   mute_o
);
  opt_vec_t level_w;
  opt_vec_t press_w;
  opt_vec_t sel_w;
  logic     change_w;
  logic     mute_w;
  code_t    code_n;
  mode_e    mode;

  for (genvar g = 0; g < OPT_N; g++) begin : g_deb
    dly_sel_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (touch_i[g]),
      .level_o(level_w[g]),
      .press_o(press_w[g])
    );
  end

  dly_sel_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .press_i (press_w),
    .sel_o   (sel_w),
    .change_o(change_w)
  );

  dly_sel_mute #(.MUTE_CYCLES(MUTE_CYCLES)) u_mute (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (change_w),
    .active_o(mute_w)
  );

  // thermometer: bit j is set when the held option index exceeds j
  for (genvar j = 0; j < CODE_W; j++) begin : g_thermo
    assign code_n[j] = |sel_w[OPT_N-1:j+1];
  end

  assign mode = mode_e'(reverb_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_code_o <= '0;
      mute_o     <= '0;
    end else begin
      sel_code_o <= code_n;
      mute_o[0]  <= mute_w;
      for (int c = 1; c < CONV_N; c++) begin
        mute_o[c] <= (mode == MODE_REVERB) ? mute_w : 1'b1;
      end
    end
  end

  AST_CODE_THERMO: assert property (@(posedge clk) disable iff (rst)
    ((sel_code_o & (sel_code_o + 1'b1)) == '0)); // R2

  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reverb_i |=> (&mute_o[CONV_N-1:1])); // R10

  AST_REVERB_SHARE: assert property (@(posedge clk) disable iff (rst)
    reverb_i |=> (mute_o[CONV_N-1:1] == {(CONV_N-1){mute_o[0]}})); // R9

  AST_CHANGE_MUTES: assert property (@(posedge clk) disable iff (rst)
    change_w |=> ##1 mute_o[0]); // R6
endmodule

// File: tb/sim_dly_sel_top.sv
`timescale 1ns/1ps
module sim_dly_sel_top;
  localparam int DEB  = 4;
  localparam int MUTE = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] touch_i = '0;
  logic       reverb_i = 1'b1;
  logic [6:0] sel_code_o;
  logic [2:0] mute_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dly_sel_top #(.DEB_CYCLES(DEB), .MUTE_CYCLES(MUTE)) u0 (
    .clk(clk), .rst(rst), .touch_i(touch_i), .reverb_i(reverb_i),
    .sel_code_o(sel_code_o), .mute_o(mute_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive mask for hold cycles, observe 70 cycles, return muted-cycle count
  task automatic press_count(input logic [7:0] mask, input int hold,
                             input logic [7:0] mask2, input int gap,
                             output int muted, output int echo_bad);
    muted = 0;
    echo_bad = 0;
    for (int t = 0; t < 70; t++) begin
      @(negedge clk);
      touch_i = '0;
      if (t < hold) touch_i = touch_i | mask;
      if (gap > 0 && t >= gap && t < gap + hold) touch_i = touch_i | mask2;
      if (mute_o[0]) muted++;
      if (!reverb_i && mute_o[2:1] != 2'b11) echo_bad++;
      if (reverb_i && mute_o[2:1] != {2{mute_o[0]}}) echo_bad++;
    end
    touch_i = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 code", sel_code_o, 0);
    check("R1 mute", mute_o[0], 0);
  endtask

  task automatic t_walk;
    int m, e;
    for (int k = 1; k < 8; k++) begin
      press_count(8'(1 << k), 8, 8'h0, 0, m, e);
      check("R2 code", sel_code_o, (1 << k) - 1);
      check("R6 pulse len", m, MUTE);
      check("R9 shared", e, 0);
    end
    press_count(8'h01, 8, 8'h0, 0, m, e);
    check("R3 back to 0", sel_code_o, 0);
  endtask

  task automatic t_repress;
    int m, e;
    press_count(8'h01, 8, 8'h0, 0, m, e);
    check("R7 no mute", m, 0);
    check("R3 held", sel_code_o, 0);
  endtask

  task automatic t_simul;
    int m, e;
    press_count(8'b1010_0100, 8, 8'h0, 0, m, e);
    check("R4 lowest", sel_code_o, 3);
    check("R4 mute", m, MUTE);
  endtask

  task automatic t_glitch;
    int m, e;
    press_count(8'h80, 2, 8'h0, 0, m, e);
    check("R5 code kept", sel_code_o, 3);
    check("R5 no mute", m, 0);
    press_count(8'h80, DEB, 8'h0, 0, m, e);
    check("R5 exact window", sel_code_o, 127);
  endtask

  task automatic t_restart;
    int m, e;
    press_count(8'h02, 6, 8'h08, 10, m, e);
    check("R8 span", m, 10 + MUTE);
    check("R8 code", sel_code_o, 7);
  endtask

  task automatic t_echo;
    int m, e;
    @(negedge clk);
    reverb_i = 1'b0;
    @(negedge clk);
    press_count(8'h10, 8, 8'h0, 0, m, e);
    check("R10 held", e, 0);
    check("R10 pulse", m, MUTE);
    check("R10 code", sel_code_o, 15);
    reverb_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 release", mute_o, 0);
  endtask

  initial begin
    t_reset();
    t_walk();
    t_repress();
    t_simul();
    t_glitch();
    t_restart();
    t_echo();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule